// File: doc/BRIEF.md
# Carry-Skip Adder

A purely combinational binary adder that takes two operands and a carry input and produces their sum and a carry output. The operand is cut into equal groups of bits. Inside a group the carry travels bit by bit. Each stage forms a bit generate signal (both operand bits high) and a bit propagate signal (the operand bits differ).

Each group also forms the AND of all its bit propagates. When that AND is true, the carry leaving the group is taken straight from the carry that entered it, so the group's ripple chain is bypassed. Otherwise the group's carry out is the carry out of its own ripple chain. A long carry therefore crosses whole groups in one multiplexer step. This keeps the worst path to roughly one ripple chain, one multiplexer per group and one final ripple chain. Both operand width and group size are parameters.

Top module: `skip_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `a_i + b_i + cin_i` for every input combination.
- R2: `cout_o` equals bit WIDTH of `a_i + b_i + cin_i`, which is the carry leaving the last group.
- R3: When every bit of a group has a_i differing from b_i, the group passes its incoming carry unchanged to the next group, by the bypass path. With `b_i = ~a_i` this gives `cout_o == cin_i` and every sum bit equal to `~cin_i`.
- R4: A bit position where a_i and b_i are both 1 sends a carry of 1 into the next position, whatever the carry arriving at that position.
- R5: A bit position where a_i and b_i are both 0 sends a carry of 0 into the next position, whatever the carry arriving at that position.
- R6: WIDTH must be a whole multiple of GROUP. Elaboration stops with an error otherwise. The adder is correct for any such pair, including a group size of 1 and a single group covering the whole width.
- R7: The block holds no state. Its outputs settle in the same cycle that the inputs change, with no clock or latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into the least significant bit |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the most significant group |

## Verification
Every result of this adder is due in the same cycle that its inputs are applied, so no result has any latency. The bench drives a new operand triple just after a rising clock edge. It compares both outputs at the following falling edge, half a period later, when the logic has settled and no edge is pending. Two configurations are swept exhaustively over every combination of operands and carry input: eight bits in groups of four, and six bits in groups of two. Directed vectors then target a full bypass, a generate at the bottom of the operand and a kill at the bottom of the operand.

// File: rtl/skip_adder.sv
module skip_adder #(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int NGRP = WIDTH / GROUP;

  if (WIDTH % GROUP != 0 || GROUP < 1) begin : g_bad_split_R6
    $error("skip_adder: WIDTH must be a multiple of GROUP");
  end

  logic [WIDTH-1:0] prop, gen;
  logic [WIDTH:0]   bc;
  logic [NGRP:0]    gcar;
  logic [NGRP-1:0]  gprop, rip;
  logic [WIDTH-1:0] sum_w;

  always_comb begin
    prop  = a_i ^ b_i;
    gen   = a_i & b_i;
    bc    = '0;
    gcar  = '0;
    gprop = '0;
    rip   = '0;
    gcar[0] = cin_i;
    for (int j = 0; j < NGRP; j++) begin
      bc[j*GROUP] = gcar[j];
      gprop[j] = 1'b1;
      for (int i = 0; i < GROUP; i++) begin
        bc[j*GROUP+i+1] = gen[j*GROUP+i] | (prop[j*GROUP+i] & bc[j*GROUP+i]);
        gprop[j] = gprop[j] & prop[j*GROUP+i];
      end
      rip[j] = bc[(j+1)*GROUP];
      gcar[j+1] = gprop[j] ? gcar[j] : rip[j];
    end
    sum_w = prop ^ bc[WIDTH-1:0];

    for (int j = 0; j < NGRP; j++) begin
      if (gprop[j]) begin
        assert_skip_pass_R3: assert (gcar[j+1] == gcar[j]);
        assert_skip_agrees_R3: assert (rip[j] == gcar[j]);
      end
    end
    for (int k = 0; k < WIDTH; k++) begin
      if (gen[k]) begin
        assert_generate_R4: assert (bc[k+1]);
      end
      if (!a_i[k] && !b_i[k]) begin
        assert_kill_R5: assert (!bc[k+1]);
      end
    end
    assert_total_R1: assert ({gcar[NGRP], sum_w} ==
                             ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}));
  end

  assign sum_o  = sum_w;
  assign cout_o = gcar[NGRP];
endmodule

// File: tb/sim_skip_adder.sv
module sim_skip_adder;
  localparam int W0 = 8;
  localparam int G0 = 4;
  localparam int W1 = 6;
  localparam int G1 = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [W0-1:0] a0, b0, s0;
  logic          c0, co0;
  logic [W1-1:0] a1, b1, s1;
  logic          c1, co1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  skip_adder #(.WIDTH(W0), .GROUP(G0)) u0 (
    .a_i(a0), .b_i(b0), .cin_i(c0), .sum_o(s0), .cout_o(co0));
  skip_adder #(.WIDTH(W1), .GROUP(G1)) u1 (
    .a_i(a1), .b_i(b1), .cin_i(c1), .sum_o(s1), .cout_o(co1));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run0(input int a, input int b, input int c, input string tag);
    int tot;
    @(posedge clk);
    a0 = a[W0-1:0]; b0 = b[W0-1:0]; c0 = c[0];
    tot = (a & 8'hff) + (b & 8'hff) + (c & 1);
    @(negedge clk);
    chk({tag, " R1 sum"}, int'(s0), tot & 8'hff);
    chk({tag, " R2 cout"}, int'(co0), (tot >> W0) & 1);
  endtask

  initial begin
    a0 = '0; b0 = '0; c0 = 1'b0;
    a1 = '0; b1 = '0; c1 = 1'b0;
    @(negedge clk);
    chk("R7 idle zero sum", int'(s0), 0);
    chk("R7 idle zero cout", int'(co0), 0);

    for (int v = 0; v < (1 << (2*W0+1)); v++) begin
      run0(v & 8'hff, (v >> 8) & 8'hff, (v >> 16) & 1, "sweep8");
    end

    for (int v = 0; v < (1 << (2*W1+1)); v++) begin
      int tot;
      @(posedge clk);
      a1 = v[5:0]; b1 = v[11:6]; c1 = v[12];
      tot = (v & 6'h3f) + ((v >> 6) & 6'h3f) + ((v >> 12) & 1);
      @(negedge clk);
      chk("R6 R1 sweep6 sum", int'(s1), tot & 6'h3f);
      chk("R6 R2 sweep6 cout", int'(co1), (tot >> W1) & 1);
    end

    // R3 full bypass: b = ~a, carry passes straight through
    for (int c = 0; c < 2; c++) begin
      @(posedge clk);
      a0 = 8'h5a; b0 = 8'ha5; c0 = c[0];
      @(negedge clk);
      chk("R3 bypass cout", int'(co0), c);
      chk("R3 bypass sum", int'(s0), c ? 0 : 8'hff);
    end
    // R4 generate at bit0 with carry in 0: upper all-propagate bits see carry
    @(posedge clk);
    a0 = 8'hff; b0 = 8'h01; c0 = 1'b0;
    @(negedge clk);
    chk("R4 generate cout", int'(co0), 1);
    chk("R4 generate sum", int'(s0), 0);
    // R5 kill at bit0 with carry in 1: upper propagate bits see no carry
    @(posedge clk);
    a0 = 8'hfe; b0 = 8'h00; c0 = 1'b1;
    @(negedge clk);
    chk("R5 kill cout", int'(co0), 0);
    chk("R5 kill sum", int'(s0), 8'hff);
    // R7 same-cycle response after a change
    run0(8'h80, 8'h80, 1, "R7 change");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule